// File: doc/BRIEF.md
# Mailbox interrupt flags with FIFO remap

This block holds the 32 completion flags of a message-buffer controller. Each transmit or receive engine raises a one-cycle pulse on its buffer's line when that buffer finishes, and the matching flag is set. The host reads all flags in parallel and clears them by writing ones. An interrupt request is raised when any flag is set and the matching bit of a mask input is also set.

A FIFO-enable input changes the meaning of the eight lowest flags. While the receive FIFO is on, a six-entry occupancy counter follows receive-into-FIFO pulses and host pop strobes. Bit 7 then reports a lost frame, bit 6 reports that the FIFO is almost full, and bit 5 reports that frames are waiting. Bits 0 to 4 are held at zero. Only frame counts are tracked. No frame data is stored.

Top module: `mailbox_irq_flags`

## Requirements
- R1: After a synchronous reset, all 32 flags and the interrupt request are 0.
- R2: With FIFO mode off, a pulse on done_i[n] sets flag n. The flag is visible on flags_o one clock after the pulse.
- R3: When wr_en_i is high, each 1 in wr_data_i clears that flag one clock later. A 0 bit leaves its flag unchanged.
- R4: If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Flags 8 to 31 behave as per-buffer flags in both modes.
- R6: With FIFO mode on, flags 0 to 4 read 0, and done_i[7:0] has no effect.
- R7: In FIFO mode, a push raises the occupancy when it is below 6. A pop lowers it when it is above 0. A push and a pop in the same cycle leave it unchanged. The occupancy is observed through flags 5, 6 and 7.
- R8: In FIFO mode, a push with no pop while 6 entries are held loses the frame and sets flag 7.
- R9: In FIFO mode, a push that takes the occupancy from 3 to 4 sets flag 6.
- R10: In FIFO mode, flag 5 is set on every cycle in which the updated occupancy is non-zero, so a host clear has no effect until the FIFO is empty.
- R11: irq_o is the OR of flags_o AND int_mask_i. It is registered, so it changes on the same edge as the flags, using the mask as it was at that edge.
- R12: Any change of fifo_en_i clears flags 0 to 7 and empties the occupancy. In that cycle, pushes, pops and done_i[7:0] are ignored.
- R13: With FIFO mode off, push and pop strobes have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | Selects FIFO meaning for flags 0 to 7 |
| done_i | input | 32 | Per-buffer completion pulses |
| fifo_push_i | input | 1 | A received frame is directed into the FIFO |
| fifo_pop_i | input | 1 | The host has read one frame from the FIFO |
| wr_en_i | input | 1 | Host write strobe for the flag register |
| wr_data_i | input | 32 | Write-one-to-clear data |
| int_mask_i | input | 32 | Interrupt enable per flag |
| flags_o | output | 32 | Flag register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first is a completion pulse and a host clear on the same flag. The second is a push and a pop on a full or empty FIFO. Directed steps drive each pair on one clock. They confirm that the flag survives the clear and that the full FIFO neither loses a frame nor changes its count, by checking that flag 7 stays clear and that the next lone push sets it. A random phase then mixes pulses, clears, strobes and mode flips. Every cycle is compared with a behavioural reference model that tracks the occupancy as an integer.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  localparam int REMAP_W   = 8;
  localparam int OVF_BIT   = 7;
  localparam int AFULL_BIT = 6;
  localparam int AVAIL_BIT = 5;
  localparam int RSV_TOP   = 4;
endpackage

// File: rtl/mbif_fifo_occ.sv
module mbif_fifo_occ #(
  parameter int DEPTH    = 6,
  parameter int AF_LEVEL = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mode_chg,
  input  logic push,
  input  logic pop,
  output logic ovf_evt,
  output logic af_evt,
  output logic avail
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_evt = 1'b0;
    af_evt  = 1'b0;
    if (mode_chg) begin
      cnt_d = '0;
    end else if (en) begin
      if (push && !pop) begin
        if (cnt_q < CW'(DEPTH)) begin
          cnt_d  = cnt_q + 1'b1;
          af_evt = (cnt_q == CW'(AF_LEVEL - 1));
        end else begin
          ovf_evt = 1'b1;
        end
      end else if (pop && !push && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign avail = en && !mode_chg && (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  p_count_cap_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  p_both_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !mode_chg && push && pop) |=> $stable(cnt_q));
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !mode_chg && push && !pop && cnt_q == CW'(DEPTH)) |=> $stable(cnt_q));
  p_mode_empty_r12: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (cnt_q == '0));
endmodule

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank
  import mbif_pkg::*;
#(
  parameter int NBUF = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_en,
  input  logic            mode_chg,
  input  logic [NBUF-1:0] done,
  input  logic            wr_en,
  input  logic [NBUF-1:0] wr_data,
  input  logic            ovf_evt,
  input  logic            af_evt,
  input  logic            avail,
  output logic [NBUF-1:0] flags_q,
  output logic [NBUF-1:0] flags_d
);
  logic [NBUF-1:0] set_v;
  logic [NBUF-1:0] clr_v;

  assign clr_v = wr_en ? wr_data : '0;

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_bit
    if (gi >= REMAP_W) begin : g_plain
      assign set_v[gi]   = done[gi];
      assign flags_d[gi] = set_v[gi] | (flags_q[gi] & ~clr_v[gi]);
    end else begin : g_remap
      if (gi == OVF_BIT) begin : g_ovf
        assign set_v[gi] = fifo_en ? ovf_evt : done[gi];
      end else if (gi == AFULL_BIT) begin : g_af
        assign set_v[gi] = fifo_en ? af_evt : done[gi];
      end else if (gi == AVAIL_BIT) begin : g_av
        assign set_v[gi] = fifo_en ? avail : done[gi];
      end else begin : g_rsv
        assign set_v[gi] = fifo_en ? 1'b0 : done[gi];
      end
      if (gi <= RSV_TOP) begin : g_rsv_clr
        assign flags_d[gi] = (mode_chg || fifo_en) ? 1'b0
                           : (set_v[gi] | (flags_q[gi] & ~clr_v[gi]));
      end else begin : g_fifo_bit
        assign flags_d[gi] = mode_chg ? 1'b0
                           : (set_v[gi] | (flags_q[gi] & ~clr_v[gi]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  p_set_upper_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q[NBUF-1:REMAP_W] & $past(done[NBUF-1:REMAP_W]))
              == $past(done[NBUF-1:REMAP_W])));
  p_w1c_upper_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((flags_q[NBUF-1:REMAP_W]
                & $past(wr_data[NBUF-1:REMAP_W] & ~done[NBUF-1:REMAP_W])) == '0));
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_en |=> (flags_q[RSV_TOP:0] == '0));
  p_mode_clear_r12: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (flags_q[REMAP_W-1:0] == '0));
endmodule

// File: rtl/mailbox_irq_flags.sv
module mailbox_irq_flags #(
  parameter int NBUF       = 32,
  parameter int FIFO_DEPTH = 6,
  parameter int AF_LEVEL   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_en_i,
  input  logic [NBUF-1:0] done_i,
  input  logic            fifo_push_i,
  input  logic            fifo_pop_i,
  input  logic            wr_en_i,
  input  logic [NBUF-1:0] wr_data_i,
  input  logic [NBUF-1:0] int_mask_i,
  output logic [NBUF-1:0] flags_o,
  output logic            irq_o
);
  logic            fifo_en_q;
  logic            mode_chg;
  logic            ovf_evt, af_evt, avail;
  logic [NBUF-1:0] flags_d;

  assign mode_chg = fifo_en_i ^ fifo_en_q;

  mbif_fifo_occ #(.DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)) u_occ (
    .clk(clk), .rst(rst), .en(fifo_en_i), .mode_chg(mode_chg),
    .push(fifo_push_i), .pop(fifo_pop_i),
    .ovf_evt(ovf_evt), .af_evt(af_evt), .avail(avail)
  );

  mbif_flag_bank #(.NBUF(NBUF)) u_bank (
    .clk(clk), .rst(rst), .fifo_en(fifo_en_i), .mode_chg(mode_chg),
    .done(done_i), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .ovf_evt(ovf_evt), .af_evt(af_evt), .avail(avail),
    .flags_q(flags_o), .flags_d(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= fifo_en_i;
      irq_o     <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en_i;
      irq_o     <= |(flags_d & int_mask_i);
    end
  end

  p_irq_match_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags_o & $past(int_mask_i)));
endmodule

// File: tb/mailbox_irq_flags_tb_top.sv
module mailbox_irq_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en = 1'b0;
  logic [31:0] done = '0;
  logic        push = 1'b0, pop = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, mask = '0;
  logic [31:0] flags;
  logic        irq;

  int checks = 0, fails = 0;
  logic [31:0] m_flags = '0;
  logic        m_irq = 1'b0;
  logic        m_prev = 1'b0;
  int          m_cnt = 0;

  always #10 clk = ~clk;

  mailbox_irq_flags dut_i (
    .clk(clk), .rst(rst), .fifo_en_i(fifo_en), .done_i(done),
    .fifo_push_i(push), .fifo_pop_i(pop), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .int_mask_i(mask), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [31:0] s, c, n;
    bit chg;
    int nc;
    if (rst) begin
      m_flags = '0; m_cnt = 0; m_prev = fifo_en; m_irq = 1'b0;
      return;
    end
    chg = (fifo_en != m_prev);
    s = '0;
    c = wr_en ? wr_data : '0;
    s[31:8] = done[31:8];
    nc = m_cnt;
    if (!fifo_en) s[7:0] = done[7:0];
    if (chg) nc = 0;
    else if (fifo_en) begin
      if (push && !pop) begin
        if (m_cnt < 6) begin nc = m_cnt + 1; if (m_cnt == 3) s[6] = 1'b1; end
        else s[7] = 1'b1;
      end else if (pop && !push && m_cnt > 0) nc = m_cnt - 1;
      if (nc > 0) s[5] = 1'b1;
    end
    n = s | (m_flags & ~c);
    if (chg) n[7:0] = '0;
    if (fifo_en) n[4:0] = '0;
    m_flags = n; m_cnt = nc; m_prev = fifo_en;
    m_irq = |(n & mask);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(flags === m_flags, "model flags", flags, m_flags);
    chk(irq === m_irq, "model irq R11", {31'b0, irq}, {31'b0, m_irq});
    done = '0; push = 1'b0; pop = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wclr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
  end

  initial begin
    step(); step();
    chk(flags == 0, "R1 flags after reset", flags, 0);
    chk(irq == 0, "R1 irq after reset", {31'b0, irq}, 0);
    rst = 1'b0;
    step();
    // R2: set from pulses
    done = 32'h0010_0008; step();
    chk(flags == 32'h0010_0008, "R2 set", flags, 32'h0010_0008);
    // R3: write one clears, zero keeps
    wclr(32'h0000_0008);
    chk(flags == 32'h0010_0000, "R3 w1c", flags, 32'h0010_0000);
    wclr(32'h0);
    chk(flags == 32'h0010_0000, "R3 zero write", flags, 32'h0010_0000);
    // R4: set wins over clear
    done = 32'h200; wr_en = 1'b1; wr_data = 32'h200; step();
    chk(flags[9] == 1'b1, "R4 set wins", flags, 32'h200);
    // R11: masked irq
    mask = 32'h0010_0000; step();
    chk(irq == 1'b1, "R11 irq on", {31'b0, irq}, 1);
    mask = 32'h0000_0001; step();
    chk(irq == 1'b0, "R11 irq off", {31'b0, irq}, 0);
    wclr(32'hFFFF_FFFF);
    // R13: strobes ignored in buffer mode
    push = 1'b1; step(); push = 1'b1; step(); pop = 1'b1; step();
    chk(flags == 0, "R13 strobes ignored", flags, 0);
    // R12: entering FIFO mode clears low byte
    done = 32'hFF; step();
    chk(flags[7:0] == 8'hFF, "R2 low byte", flags, 32'hFF);
    fifo_en = 1'b1; push = 1'b1; step();
    chk(flags[7:0] == 0, "R12 enter clears", flags, 0);
    // R6, R5
    done = 32'h0000_10FF; step();
    chk(flags == 32'h0000_1000, "R6 R5 remap", flags, 32'h1000);
    wclr(32'h1000);
    // R10
    push = 1'b1; step();
    chk(flags[5] == 1'b1, "R10 avail set", flags, 32'h20);
    wclr(32'h20);
    chk(flags[5] == 1'b1, "R10 avail resists clear", flags, 32'h20);
    // R9
    push = 1'b1; step(); push = 1'b1; step();
    chk(flags[6] == 1'b0, "R9 at three", flags, 32'h20);
    push = 1'b1; step();
    chk(flags[6] == 1'b1, "R9 at four", flags, 32'h60);
    // R8, R7
    push = 1'b1; step(); push = 1'b1; step();
    chk(flags[7] == 1'b0, "R7 six held no loss", flags, 32'h60);
    push = 1'b1; step();
    chk(flags[7] == 1'b1, "R8 overflow", flags, 32'hE0);
    wclr(32'h80);
    push = 1'b1; pop = 1'b1; step();
    chk(flags[7] == 1'b0, "R7 push and pop at full", flags, 32'h60);
    push = 1'b1; step();
    chk(flags[7] == 1'b1, "R7 still full", flags, 32'hE0);
    for (int i = 0; i < 7; i++) begin pop = 1'b1; step(); end
    wclr(32'hE0);
    step();
    chk(flags[7:5] == 0, "R10 empty clears", flags, 0);
    push = 1'b1; pop = 1'b1; step();
    chk(flags[5] == 1'b0, "R7 push and pop at empty", flags, 0);
    push = 1'b1; step();
    chk(flags[5] == 1'b1, "R10 one frame", flags, 32'h20);
    // R12: leaving FIFO mode
    fifo_en = 1'b0; step();
    chk(flags[7:0] == 0, "R12 leave clears", flags, 0);
    done = 32'h20; step();
    chk(flags[5] == 1'b1, "R2 bit five as buffer", flags, 32'h20);
    // random phase against the model
    for (int k = 0; k < 2000; k++) begin
      if (($urandom % 40) == 0) fifo_en = ~fifo_en;
      done    = $urandom & $urandom & $urandom;
      push    = ($urandom % 3) != 0;
      pop     = ($urandom % 3) == 0;
      wr_en   = ($urandom % 4) == 0;
      wr_data = $urandom;
      mask    = $urandom;
      step();
    end
    summary();
  end
endmodule